// File: doc/BRIEF.md
# I2C Register-Pointer Slave

This block is a bus slave on a two-wire serial link. It gives an external master byte-wide access to a register file held elsewhere on the chip. Both bus lines are sampled with the system clock through a short synchronizer. The block drives only an open-drain pull-down enable for the data line.

After a matching address with the write direction, the first byte the master sends is taken as the register pointer. Each later byte is written to the register file at the pointer, and the pointer then steps by one. To read, the master sets the pointer with a write, then issues a repeated START and the same address with the read direction. The slave then returns the register at the pointer. Every read byte the master acknowledges moves the pointer on and fetches the next register.

A STOP always returns the pointer to zero. The register file attaches through a plain port: address, write data, a one-cycle write strobe and combinational read data.

Top module: `i2c_regslave`

## Requirements
- R1: A falling data line while the clock line is high is a START, and it begins an address phase even in the middle of a transfer. A rising data line while the clock line is high is a STOP.
- R2: The first byte after START is taken MSB first. Bits 7..1 are the address and bit 0 is the direction (0 = write, 1 = read). When bits 7..1 equal `DEV_ADDR`, the slave pulls the data line low for the whole 9th clock.
- R3: When the address does not match, the slave gives no acknowledge, writes nothing and leaves the data line released until the next START.
- R4: The first byte after a write address is acknowledged and loaded into the 8-bit pointer, which appears on `reg_addr`.
- R5: Each further write byte is acknowledged. It produces one `reg_we` pulse of one clock, with `reg_addr` at the pointer and `reg_wdata` equal to the byte. The pointer then increments by one.
- R6: After a read address is acknowledged, the slave sends `reg_rdata` at the pointer MSB first, with `sda_oe` high for each 0 bit.
- R7: A master acknowledge (data low on the 9th clock) of a read byte increments the pointer and starts the next byte. A master no-acknowledge stops all driving until the next START.
- R8: A STOP sets the pointer to 0x00 and releases the data line.
- R9: `sda_oe` changes only while the clock line is low.
- R10: A START or STOP that arrives part-way through a byte drops that byte, and no write takes place.
- R11: The pointer wraps from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | 8 | Register pointer, address to the register file |
| reg_wdata | output | 8 | Byte to be written |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register file contents at `reg_addr` |

## Verification
The hardest situations to reach are a START or STOP that lands part-way through a byte, and a pointer carried across 0xFF. The bench drives the bus bit by bit rather than byte by byte. This lets it cut a byte after three or four bits and then issue a STOP or a fresh START. It then confirms that no write strobe appeared and that the next full transfer lands where expected. For the wrap case, the bench loads the pointer with 0xFF and writes two bytes.

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter logic [6:0] DEV_ADDR = 7'h3A,
  parameter int         SYNC     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  typedef enum logic [2:0] {IDLE, ADDR, WR, RD, SKIP} st_t;

  logic [SYNC-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;
  wire  scl_s = scl_sh[SYNC-1];
  wire  sda_s = sda_sh[SYNC-1];

  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;

  st_t        st;
  logic [3:0] bcnt;
  logic [7:0] sr, ptr;
  logic       rw, got_cmd, we_r;

  wire [7:0] byte_in = {sr[6:0], sda_s};

  assign reg_addr  = ptr;
  assign reg_wdata = sr;
  assign reg_we    = we_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      bcnt    <= '0;
      sr      <= '0;
      ptr     <= '0;
      rw      <= 1'b0;
      got_cmd <= 1'b0;
      we_r    <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      we_r <= 1'b0;
      if (we_r) ptr <= ptr + 8'd1;
      if (start_det) begin
        st      <= ADDR;
        bcnt    <= '0;
        got_cmd <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        st     <= IDLE;
        bcnt   <= '0;
        ptr    <= '0;
        sda_oe <= 1'b0;
      end else if (st == ADDR || st == WR || st == RD) begin
        if (scl_rise) begin
          if (bcnt < 4'd8) begin
            bcnt <= bcnt + 4'd1;
            if (st != RD) begin
              sr <= byte_in;
              if (bcnt == 4'd7) begin
                if (st == ADDR) begin
                  if (byte_in[7:1] == DEV_ADDR) rw <= byte_in[0];
                  else st <= SKIP;
                end else if (!got_cmd) begin
                  ptr     <= byte_in;
                  got_cmd <= 1'b1;
                end else begin
                  we_r <= 1'b1;
                end
              end
            end
          end else if (bcnt == 4'd8) begin
            bcnt <= 4'd9;
            if (st == RD) begin
              if (!sda_s) ptr <= ptr + 8'd1;
              else        st  <= SKIP;
            end
          end
        end else if (scl_fall) begin
          if (bcnt == 4'd8) begin
            sda_oe <= (st != RD);
          end else if (bcnt == 4'd9) begin
            bcnt <= '0;
            if ((st == ADDR && rw) || st == RD) begin
              st     <= RD;
              sr     <= reg_rdata;
              sda_oe <= ~reg_rdata[7];
            end else begin
              st     <= WR;
              sda_oe <= 1'b0;
            end
          end else if (st == RD && bcnt != 4'd0) begin
            sda_oe <= ~sr[3'd7 - bcnt[2:0]];
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [7:0] reg_addr
);
  a_r9_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_addr == $past(reg_addr) + 8'd1);
  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (reg_addr == 8'h00 && !sda_oe));
endmodule

bind i2c_regslave i2c_regslave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_det(stop_det),
  .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/sim_i2c_regslave.sv
module sim_i2c_regslave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam logic [6:0] ADR = 7'h3A;

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] regs [256];
  logic [7:0] expm [256];
  wire  sda_bus = sda_m & ~sda_oe;
  int   errors = 0, checks = 0, we_cnt = 0, r9_bad = 0, cyc = 0;
  logic prev_oe = 0, prev_scl = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regslave #(.DEV_ADDR(ADR)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata));

  assign reg_rdata = regs[reg_addr];
  always @(posedge clk) if (reg_we) regs[reg_addr] <= reg_wdata;

  always @(negedge clk) begin
    cyc++;
    if (reg_we) we_cnt++;
    if (sda_oe !== prev_oe && (scl_m || prev_scl)) r9_bad++;
    prev_oe  = sda_oe;
    prev_scl = scl_m;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1; w(HALF); scl_m = 1; w(HALF); sda_m = 0; w(HALF); scl_m = 0; w(2);
  endtask

  task automatic bstop();
    sda_m = 0; w(HALF); scl_m = 1; w(HALF); sda_m = 1; w(HALF);
  endtask

  task automatic bit_io(input logic b, output logic s);
    sda_m = b; w(HALF); scl_m = 1; w(HALF/2); s = sda_bus; w(HALF/2); scl_m = 0; w(2);
  endtask

  task automatic send_bits(input logic [7:0] d, input int n);
    logic s;
    for (int i = 7; i > 7 - n; i--) bit_io(d[i], s);
  endtask

  task automatic send(input logic [7:0] d, output logic ack);
    logic s;
    send_bits(d, 8);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); d[i] = s; end
    bit_io(~mack, s);
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    int base;
    for (int i = 0; i < 256; i++) begin regs[i] = 8'(i ^ 8'h5A); expm[i] = 8'(i ^ 8'h5A); end
    w(4);
    chk(sda_oe == 0 && reg_we == 0 && reg_addr == 0, "R8 reset", {sda_oe, reg_we, reg_addr}, 0);
    rst_n = 1; w(4);

    bstart();
    send({ADR, 1'b0}, a); chk(a == 1, "R1 R2 addr ack", a, 1);
    send(8'h10, a); chk(a == 1, "R4 cmd ack", a, 1);
    chk(reg_addr == 8'h10, "R4 pointer load", reg_addr, 8'h10);
    send(8'hA5, a); expm[8'h10] = 8'hA5;
    send(8'h3C, a); expm[8'h11] = 8'h3C; chk(a == 1, "R5 data ack", a, 1);
    chk(regs[8'h10] == 8'hA5, "R5 write 0x10", regs[8'h10], 8'hA5);
    chk(regs[8'h11] == 8'h3C, "R5 write 0x11", regs[8'h11], 8'h3C);
    chk(reg_addr == 8'h12, "R5 pointer step", reg_addr, 8'h12);
    chk(we_cnt == 2, "R5 strobe count", we_cnt, 2);
    bstop();
    chk(reg_addr == 8'h00, "R8 stop clears pointer", reg_addr, 0);

    base = we_cnt;
    bstart();
    send({7'h21, 1'b0}, a); chk(a == 0, "R3 no ack on mismatch", a, 0);
    send(8'h10, a); chk(a == 0, "R3 bytes ignored", a, 0);
    send(8'hEE, a);
    chk(we_cnt == base && regs[8'h10] == 8'hA5, "R3 no write", we_cnt - base, 0);
    bstop();

    bstart();
    send({ADR, 1'b0}, a); send(8'h10, a);
    bstart();
    send({ADR, 1'b1}, a); chk(a == 1, "R6 read addr ack", a, 1);
    recv(1'b1, d); chk(d == expm[8'h10], "R6 first read byte", d, expm[8'h10]);
    recv(1'b1, d); chk(d == expm[8'h11], "R7 ack gives next", d, expm[8'h11]);
    recv(1'b0, d); chk(d == expm[8'h12], "R7 third byte", d, expm[8'h12]);
    recv(1'b0, d); chk(d == 8'hFF, "R7 released after nack", d, 8'hFF);
    bstop();

    bstart();
    send({ADR, 1'b0}, a); send(8'hFF, a);
    send(8'h11, a); expm[8'hFF] = 8'h11;
    send(8'h22, a); expm[8'h00] = 8'h22;
    chk(regs[8'hFF] == 8'h11 && regs[8'h00] == 8'h22, "R11 wrap write", regs[8'h00], 8'h22);
    chk(reg_addr == 8'h01, "R11 pointer after wrap", reg_addr, 1);
    bstop();

    base = we_cnt;
    bstart();
    send({ADR, 1'b0}, a); send(8'h40, a);
    send_bits(8'hFF, 4);
    bstop();
    chk(we_cnt == base && regs[8'h40] == expm[8'h40], "R10 stop mid-byte no write", we_cnt - base, 0);
    chk(reg_addr == 8'h00, "R8 R10 pointer after abort", reg_addr, 0);

    bstart();
    send({ADR, 1'b0}, a); send(8'h50, a);
    send_bits(8'h00, 3);
    bstart();
    send({ADR, 1'b0}, a); chk(a == 1, "R1 R10 start mid-byte restarts", a, 1);
    send(8'h60, a); send(8'h77, a); expm[8'h60] = 8'h77;
    bstop();
    chk(regs[8'h60] == 8'h77 && regs[8'h50] == expm[8'h50], "R10 data after restart", regs[8'h60], 8'h77);

    chk(r9_bad == 0, "R9 sda_oe moves only with clock low", r9_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule